// File: doc/BRIEF.md
# Per-Byte Dependence Record Tracker

This block sits beside a private cache and decides when a local load or store has to trigger a dedicated metadata-exchange bus transaction. Inside a multi-word line, a dependence on one word can reach the local core without any coherence traffic, for example when the line is already held and another word was the one that changed. The tracker keeps one recorded-state bit for every byte of each tracked line. A set bit means that the most recent inter-thread dependence on that byte has already been exchanged. A clear bit means it has not.

On each local access the tracker builds the byte span covered by the access and compares it with the line's bits. If any covered bit is clear and no coherence transaction is already being issued for the access, the tracker raises a one-cycle force request. When the exchange finishes, whether through a coherence transaction or a forced access, completion sets the covered bits. Remote read or write notifications clear the bits they cover, because each one is a new dependence source.

Lines are held in a small direct-mapped table indexed by the low bits of the line address. An access that misses replaces the entry, and the new entry starts with every bit clear.

Top module: `dep_rec_tracker`

## Requirements
- R1: After reset, force_req is low and no line is tracked.
- R2: A local access to a line that is not tracked (the entry is invalid, or it holds another tag) allocates that entry with all 32 bits clear. When acc_coh is 0, force_req goes high in the cycle after the access.
- R3: An access presented with acc_coh=1 never raises force_req.
- R4: The access span is acc_off up to acc_off+2^acc_size-1, clipped at byte 31. acc_size encodes 0=1, 1=2, 2=4 and 3=8 bytes. With acc_coh=0, force_req goes high in the cycle after the access exactly when at least one byte in that span has a clear bit.
- R5: A done_valid pulse sets the bits of the span of the latest access that raised force_req or carried acc_coh=1. After that, the same access no longer forces.
- R6: A remote notification (rmt_line, rmt_off, rmt_size, span encoded as in R4) clears the bits in its span when its line is tracked. A notification to an untracked line has no effect.
- R7: force_req is a single-cycle pulse for each forcing access, and it is never high without an access in the cycle before.
- R8: When done_valid and a remote notification arrive in the same cycle for the same byte, the clear wins and the byte stays unrecorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Local access present this cycle |
| acc_line | input | 16 | Line address of the local access |
| acc_off | input | 5 | First byte of the access in the line |
| acc_size | input | 2 | Log2 of the access length in bytes |
| acc_coh | input | 1 | A coherence transaction is already issued for this access |
| rmt_valid | input | 1 | Remote read or write notification present |
| rmt_line | input | 16 | Line address of the remote access |
| rmt_off | input | 5 | First byte of the remote span |
| rmt_size | input | 2 | Log2 of the remote span length |
| done_valid | input | 1 | Metadata exchange of the pending access completed |
| force_req | output | 1 | Request for a forced metadata bus access |

## Verification
Every start offset is combined with every access size. Each combination is tried on a fresh line (which must force), again after completion (which must not force), and after a single remote byte is cleared at a varying position. The last case separates spans that cover that byte from spans that stop just short of it, including spans clipped at the line end. Directed patterns cover the remaining cases. An access with a coherence transaction in flight must stay quiet. A notification to a line that shares the index but has a different tag must change nothing. A remote read must clear bits just as a remote write does. When completion and a remote clear collide on the same byte, the clear must win.

// File: rtl/dep_rec_pkg.sv
package dep_rec_pkg;
    localparam int unsigned DEF_LINE_BYTES  = 32;
    localparam int unsigned DEF_NUM_LINES   = 4;
    localparam int unsigned DEF_LINE_ADDR_W = 16;
    localparam int unsigned DEF_SIZE_W      = 2;
endpackage

// File: rtl/dep_rec_span.sv
module dep_rec_span #(
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned SIZE_W     = 2,
    parameter int unsigned OFF_W      = $clog2(LINE_BYTES)
) (
    input  logic [OFF_W-1:0]      off,
    input  logic [SIZE_W-1:0]     size,
    output logic [LINE_BYTES-1:0] mask
);
    localparam int unsigned END_W = OFF_W + (1 << SIZE_W) + 1;

    logic [END_W-1:0] lo;
    logic [END_W-1:0] hi;

    assign lo = END_W'(off);
    assign hi = lo + (END_W'(1) << size);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        assign mask[b] = (END_W'(b) >= lo) && (END_W'(b) < hi);
    end
endmodule

// File: rtl/dep_rec_lookup.sv
module dep_rec_lookup #(
    parameter int unsigned NUM_LINES   = 4,
    parameter int unsigned LINE_ADDR_W = 16,
    parameter int unsigned IDX_W       = $clog2(NUM_LINES),
    parameter int unsigned TAG_W       = LINE_ADDR_W - IDX_W
) (
    input  logic [NUM_LINES-1:0]            valid,
    input  logic [NUM_LINES-1:0][TAG_W-1:0] tags,
    input  logic [LINE_ADDR_W-1:0]          line,
    output logic                            hit,
    output logic [IDX_W-1:0]                idx
);
    logic [NUM_LINES-1:0] match;

    assign idx = line[IDX_W-1:0];

    for (genvar w = 0; w < NUM_LINES; w++) begin : g_way
        assign match[w] = valid[w] && (tags[w] == line[LINE_ADDR_W-1:IDX_W])
                          && (idx == IDX_W'(w));
    end

    assign hit = |match;
endmodule

// File: rtl/dep_rec_tracker.sv
module dep_rec_tracker
    import dep_rec_pkg::*;
#(
    parameter int unsigned LINE_BYTES  = DEF_LINE_BYTES,
    parameter int unsigned NUM_LINES   = DEF_NUM_LINES,
    parameter int unsigned LINE_ADDR_W = DEF_LINE_ADDR_W,
    parameter int unsigned SIZE_W      = DEF_SIZE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_valid,
    input  logic [LINE_ADDR_W-1:0]        acc_line,
    input  logic [$clog2(LINE_BYTES)-1:0] acc_off,
    input  logic [SIZE_W-1:0]             acc_size,
    input  logic                          acc_coh,
    input  logic                          rmt_valid,
    input  logic [LINE_ADDR_W-1:0]        rmt_line,
    input  logic [$clog2(LINE_BYTES)-1:0] rmt_off,
    input  logic [SIZE_W-1:0]             rmt_size,
    input  logic                          done_valid,
    output logic                          force_req
);
    localparam int unsigned OFF_W = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W = $clog2(NUM_LINES);
    localparam int unsigned TAG_W = LINE_ADDR_W - IDX_W;

    typedef struct packed {
        logic [NUM_LINES-1:0]                 valid;
        logic [NUM_LINES-1:0][TAG_W-1:0]      tags;
        logic [NUM_LINES-1:0][LINE_BYTES-1:0] bits;
        logic                                 pend_valid;
        logic [LINE_ADDR_W-1:0]               pend_line;
        logic [LINE_BYTES-1:0]                pend_mask;
        logic                                 force_out;
    } state_t;

    state_t st_d, st_q;

    logic [LINE_BYTES-1:0] a_mask, r_mask;
    logic                  a_hit, r_hit, p_hit;
    logic [IDX_W-1:0]      a_idx, r_idx, p_idx;
    logic                  a_need;

    dep_rec_span #(.LINE_BYTES(LINE_BYTES), .SIZE_W(SIZE_W)) u_acc_span (
        .off(acc_off), .size(acc_size), .mask(a_mask)
    );
    dep_rec_span #(.LINE_BYTES(LINE_BYTES), .SIZE_W(SIZE_W)) u_rmt_span (
        .off(rmt_off), .size(rmt_size), .mask(r_mask)
    );

    dep_rec_lookup #(.NUM_LINES(NUM_LINES), .LINE_ADDR_W(LINE_ADDR_W)) u_acc_lkp (
        .valid(st_q.valid), .tags(st_q.tags), .line(acc_line), .hit(a_hit), .idx(a_idx)
    );
    dep_rec_lookup #(.NUM_LINES(NUM_LINES), .LINE_ADDR_W(LINE_ADDR_W)) u_rmt_lkp (
        .valid(st_q.valid), .tags(st_q.tags), .line(rmt_line), .hit(r_hit), .idx(r_idx)
    );
    dep_rec_lookup #(.NUM_LINES(NUM_LINES), .LINE_ADDR_W(LINE_ADDR_W)) u_pnd_lkp (
        .valid(st_q.valid), .tags(st_q.tags), .line(st_q.pend_line), .hit(p_hit), .idx(p_idx)
    );

    // A miss counts as "every byte unrecorded"
    assign a_need = !a_hit || ((a_mask & ~st_q.bits[a_idx]) != '0);

    always_comb begin
        st_d           = st_q;
        st_d.force_out = 1'b0;

        // completion marks the pending span as recorded
        if (done_valid && st_q.pend_valid) begin
            st_d.pend_valid = 1'b0;
            if (p_hit) begin
                st_d.bits[p_idx] = st_d.bits[p_idx] | st_q.pend_mask;
            end
        end

        // local access: allocate on miss, decide on forcing, track pending span
        if (acc_valid) begin
            if (!a_hit) begin
                st_d.valid[a_idx] = 1'b1;
                st_d.tags[a_idx]  = acc_line[LINE_ADDR_W-1:IDX_W];
                st_d.bits[a_idx]  = '0;
            end
            st_d.force_out = a_need && !acc_coh;
            if (a_need || acc_coh) begin
                st_d.pend_valid = 1'b1;
                st_d.pend_line  = acc_line;
                st_d.pend_mask  = a_mask;
            end
        end

        // remote access: new dependence source, applied last so it wins
        if (rmt_valid && r_hit) begin
            st_d.bits[r_idx] = st_d.bits[r_idx] & ~r_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign force_req = st_q.force_out;
endmodule

// File: rtl/dep_rec_tracker_chk.sv
module dep_rec_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_valid,
    input logic acc_coh,
    input logic force_req
);
    AST_FORCE_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        force_req |-> $past(acc_valid)); // R7

    AST_COH_SUPPRESSES_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_coh) |=> !force_req); // R3

    AST_FORCE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (force_req && !acc_valid) |=> !force_req); // R7

    AST_FORCE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(force_req)); // R1
endmodule

bind dep_rec_tracker dep_rec_tracker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_coh(acc_coh), .force_req(force_req)
);

// File: tb/dep_rec_tracker_test.sv
module dep_rec_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_line = '0;
    logic [4:0]  acc_off = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_coh = 1'b0;
    logic        rmt_valid = 1'b0;
    logic [15:0] rmt_line = '0;
    logic [4:0]  rmt_off = '0;
    logic [1:0]  rmt_size = '0;
    logic        done_valid = 1'b0;
    logic        force_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dep_rec_tracker uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
        .acc_off(acc_off), .acc_size(acc_size), .acc_coh(acc_coh),
        .rmt_valid(rmt_valid), .rmt_line(rmt_line), .rmt_off(rmt_off),
        .rmt_size(rmt_size), .done_valid(done_valid), .force_req(force_req)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: force_req=%0b expected %0b at t=%0t", req, act, exp, $time);
        end
    endtask

    // drive one access for one cycle; on return force_req is the result
    task automatic access(input logic [15:0] ln, input int off, input int sz, input logic coh);
        @(negedge clk);
        acc_valid = 1'b1; acc_line = ln; acc_off = 5'(off); acc_size = 2'(sz); acc_coh = coh;
        @(negedge clk);
        acc_valid = 1'b0; acc_coh = 1'b0;
    endtask

    task automatic remote(input logic [15:0] ln, input int off, input int sz);
        @(negedge clk);
        rmt_valid = 1'b1; rmt_line = ln; rmt_off = 5'(off); rmt_size = 2'(sz);
        @(negedge clk);
        rmt_valid = 1'b0;
    endtask

    task automatic done();
        @(negedge clk);
        done_valid = 1'b1;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", force_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", force_req, 1'b0);

        // sweep every offset and size
        for (int off = 0; off < 32; off++) begin
            for (int sz = 0; sz < 4; sz++) begin
                logic [15:0] ln;
                int len, rb;
                logic exp;
                ln  = 16'((off * 4 + sz + 1) * 4 + 1);
                len = 1 << sz;
                access(ln, off, sz, 1'b0);
                check("R2 fresh line forces", force_req, 1'b1);
                @(negedge clk);
                check("R7 single pulse", force_req, 1'b0);
                done();
                access(ln, off, sz, 1'b0);
                check("R5 recorded span quiet", force_req, 1'b0);
                rb = (off * 7 + sz * 3 + 1) % 32;
                remote(ln, rb, 0);
                exp = (rb >= off) && (rb < off + len);
                access(ln, off, sz, 1'b0);
                check("R4 R6 span vs cleared byte", force_req, exp);
                done();
            end
        end

        // coherence transaction suppresses the force
        access(16'h0102, 0, 3, 1'b1);
        check("R3 coherent access quiet", force_req, 1'b0);
        done();
        access(16'h0102, 0, 3, 1'b0);
        check("R5 coherent completion records", force_req, 1'b0);

        // notification to a line with another tag on the same index
        remote(16'h0206, 0, 3);
        access(16'h0102, 0, 3, 1'b0);
        check("R6 untracked notify ignored", force_req, 1'b0);

        // remote read clears too
        remote(16'h0102, 5, 0);
        access(16'h0102, 4, 2, 1'b0);
        check("R6 remote read clears", force_req, 1'b1);
        done();
        access(16'h0102, 4, 2, 1'b0);
        check("R5 re-recorded", force_req, 1'b0);

        // clipped span at line end
        remote(16'h0102, 31, 0);
        access(16'h0102, 28, 3, 1'b0);
        check("R4 clipped span sees byte 31", force_req, 1'b1);
        done();
        access(16'h0102, 30, 3, 1'b0);
        check("R4 clipped span recorded", force_req, 1'b0);

        // completion and remote clear collide: clear wins
        access(16'h0302, 0, 0, 1'b0);
        check("R2 new tag forces", force_req, 1'b1);
        @(negedge clk);
        done_valid = 1'b1; rmt_valid = 1'b1; rmt_line = 16'h0302; rmt_off = 5'd0; rmt_size = 2'd0;
        @(negedge clk);
        done_valid = 1'b0; rmt_valid = 1'b0;
        access(16'h0302, 0, 0, 1'b0);
        check("R8 clear wins over completion", force_req, 1'b1);
        done();

        // idle: no access, no force
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R7 idle quiet", force_req, 1'b0);
        end

        finish_run();
    end
endmodule